// File: doc/BRIEF.md
# Four-Stage Load/Store Processor Core

This block is a small 16-bit load/store processor whose work is split across four clocked stages: fetch, decode with register read, execute, and register write-back. A new instruction can enter every cycle. Clocked stage registers between the stages carry the operands and the control bits that later stages still need. The core drives a read-only instruction port from its program counter. It also drives a single-port data memory, which is read or written in the execute stage alongside the function unit.

The instruction set holds eight operations: add, bitwise OR, shift right by one, load of a zero-filled 3-bit constant, load from memory, store to memory, branch when a register is zero, and jump to a register address. The core has no hazard detection and no forwarding between stages. Software keeps one independent instruction between a producer and its consumer, and it fills the two slots behind every branch or jump. The register file write port and the function unit status are brought out as registered ports, so a system can trace every retired result.

Top module: `pipe4_core`

## Requirements
- R1: While reset is high and afterwards, the fetch address is 0, and every stage holds a no-op. No register write and no memory write may appear in the first three cycles after reset.
- R2: Instruction word layout: opcode in bits 15..9, destination in 8..6, source A in 5..3, and source B or a 3-bit constant in 2..0. Opcodes: add 0x02, OR 0x08, shift 0x0D, constant load 0x4C, memory load 0x10, store 0x20, branch-on-zero 0x60, jump 0x70. Every other opcode is a no-op and writes neither registers nor memory, whatever its fields hold.
- R3: Add writes A+B modulo 2^16, OR writes A|B, and shift writes B>>1 (logical) to the destination register.
- R4: Constant load writes bits 2..0 zero-filled to 16 bits into the destination. It takes the operand from the constant, not from the register file.
- R5: A store drives the write strobe, address R[A] and data R[B] during its execute cycle. A memory load writes the word at address R[A] into the destination.
- R6: An instruction fetched in cycle k appears on the register write port in cycle k+3, and a store drives memory in cycle k+2. N back-to-back instructions therefore finish in N+3 cycles.
- R7: A register written in write-back is seen by a decode-stage read of that register in the same cycle. A result is thus usable two instructions after its producer.
- R8: Branch-on-zero with R[A]==0, fetched in cycle k at address p, makes the fetch address p + sign-extended bits 2..0 in cycle k+3. The two instructions behind it execute.
- R9: Branch-on-zero with R[A]!=0 leaves fetching sequential.
- R10: Jump fetched in cycle k makes the fetch address R[A] in cycle k+3. Its two following instructions execute.
- R11: Status {V,C,N,Z} (bits 3..0) updates on add, OR and shift, and holds on all other instructions. Add sets C to the carry out and V to the signed overflow. OR clears V and C. Shift clears V and sets C to the bit shifted out. N is result bit 15, and Z is set when the result is zero. The value is visible in the same cycle as that instruction's write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Fetch address (program counter) |
| imem_data | input | 16 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 16 | Data memory address, from the execute stage |
| dmem_wdata | output | 16 | Data memory write data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 16 | Data memory read word at dmem_addr, same cycle |
| rf_wr_en | output | 1 | Register file write enable in write-back |
| rf_wr_addr | output | 3 | Register being written |
| rf_wr_data | output | 16 | Value being written |
| status_flags | output | 4 | {V,C,N,Z} of the latest arithmetic/logic instruction |

## Verification
Each result has a fixed due cycle, counted from reset release with cycle 0 ending at the first clock edge. The write for an instruction at address k is due in cycle k+3, a store in cycle k+2, and a redirected fetch address three cycles after the branch or jump is fetched. For straight-line programs, the bench runs a sequential model. It tags every expected write and store with its due cycle and compares the ports at the falling edge of exactly that cycle. For branches and jumps, it samples the fetch address and the delay-slot writes at their computed cycles.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 7;
  localparam int FLD_W   = 3;
  localparam int REG_CNT = 2 ** FLD_W;
  localparam int OPC_LSB = 3 * FLD_W;
  localparam int DR_LSB  = 2 * FLD_W;
  localparam int SA_LSB  = FLD_W;
  localparam int SB_LSB  = 0;

  localparam int FLAG_W = 4;
  localparam int FLG_V  = 3;
  localparam int FLG_C  = 2;
  localparam int FLG_N  = 1;
  localparam int FLG_Z  = 0;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP = 7'h00,
    OPC_ADD = 7'h02,
    OPC_OR  = 7'h08,
    OPC_SHR = 7'h0D,
    OPC_LDI = 7'h4C,
    OPC_LD  = 7'h10,
    OPC_ST  = 7'h20,
    OPC_BZ  = 7'h60,
    OPC_JMP = 7'h70
  } opcode_e;

  typedef enum logic [1:0] {
    FU_ADD,
    FU_OR,
    FU_SHR,
    FU_PASSB
  } fu_op_e;

  typedef struct packed {
    logic   rf_we;
    logic   use_const;
    logic   sel_mem;
    logic   mem_we;
    logic   flag_we;
    logic   is_bz;
    logic   is_jmp;
    fu_op_e fu_op;
  } ctrl_t;

endpackage

// File: rtl/p4_decoder.sv
module p4_decoder
  import pipe4_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl,
  output logic [FLD_W-1:0]   fld_dr,
  output logic [FLD_W-1:0]   fld_sa,
  output logic [FLD_W-1:0]   fld_sb
);

  logic [OPC_W-1:0] opc;

  assign opc    = instr[OPC_LSB +: OPC_W];
  assign fld_dr = instr[DR_LSB +: FLD_W];
  assign fld_sa = instr[SA_LSB +: FLD_W];
  assign fld_sb = instr[SB_LSB +: FLD_W];

  always_comb begin
    ctrl = ctrl_t'('0);
    case (opc)
      OPC_ADD: begin
        ctrl.rf_we   = 1'b1;
        ctrl.flag_we = 1'b1;
        ctrl.fu_op   = FU_ADD;
      end
      OPC_OR: begin
        ctrl.rf_we   = 1'b1;
        ctrl.flag_we = 1'b1;
        ctrl.fu_op   = FU_OR;
      end
      OPC_SHR: begin
        ctrl.rf_we   = 1'b1;
        ctrl.flag_we = 1'b1;
        ctrl.fu_op   = FU_SHR;
      end
      OPC_LDI: begin
        ctrl.rf_we     = 1'b1;
        ctrl.use_const = 1'b1;
        ctrl.fu_op     = FU_PASSB;
      end
      OPC_LD: begin
        ctrl.rf_we   = 1'b1;
        ctrl.sel_mem = 1'b1;
      end
      OPC_ST:  ctrl.mem_we = 1'b1;
      OPC_BZ:  ctrl.is_bz  = 1'b1;
      OPC_JMP: ctrl.is_jmp = 1'b1;
      default: ctrl = ctrl_t'('0);
    endcase
  end

endmodule

// File: rtl/p4_regfile.sv
module p4_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ra,
  input  logic [ADDR_W-1:0] rb,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // write-before-read: a value being written this cycle is returned directly
  assign rdata_a = (we && waddr == ra) ? wdata : mem[ra];
  assign rdata_b = (we && waddr == rb) ? wdata : mem[rb];

  // R7: a written value is read back on the next cycle unless overwritten
  p_rd_after_wr_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> (ra != $past(waddr)) || (we && waddr == ra) || (rdata_a == $past(wdata)));

endmodule

// File: rtl/p4_func_unit.sv
module p4_func_unit
  import pipe4_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  fu_op_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] flags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] sum;
  logic            cry;
  logic            ovf;

  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    res = b;
    cry = 1'b0;
    ovf = 1'b0;
    case (op)
      FU_ADD: begin
        res = sum[MSB:0];
        cry = sum[DATA_W];
        ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      FU_OR:  res = a | b;
      FU_SHR: begin
        res = b >> 1;
        cry = b[0];
      end
      default: res = b;
    endcase
  end

  always_comb begin
    flags        = '0;
    flags[FLG_V] = ovf;
    flags[FLG_C] = cry;
    flags[FLG_N] = res[MSB];
    flags[FLG_Z] = (res == '0);
  end

endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
  import pipe4_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  output logic [DATA_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic [DATA_W-1:0]  dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic               rf_wr_en,
  output logic [FLD_W-1:0]   rf_wr_addr,
  output logic [DATA_W-1:0]  rf_wr_data,
  output logic [FLAG_W-1:0]  status_flags
);

  localparam int EXT_W = DATA_W - FLD_W;

  // ---------------- fetch ----------------
  logic [DATA_W-1:0]  pc_q;
  logic [DATA_W-1:0]  pc_next;
  logic               redirect;
  logic [DATA_W-1:0]  target;

  // ---------------- fetch / decode register ----------------
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  ir_pc_q;

  // ---------------- decode ----------------
  ctrl_t              dec_ctrl;
  logic [FLD_W-1:0]   dec_dr, dec_sa, dec_sb;
  logic [DATA_W-1:0]  rd_a, rd_b, const_zf, opnd_b;

  // ---------------- decode / execute register ----------------
  ctrl_t              ex_ctrl;
  logic [DATA_W-1:0]  ex_a, ex_b, ex_pc;
  logic [FLD_W-1:0]   ex_dr, ex_off;
  logic [DATA_W-1:0]  ex_off_sx;

  // ---------------- execute ----------------
  logic [DATA_W-1:0]  fu_res;
  logic [FLAG_W-1:0]  fu_flags;
  logic               bz_taken;

  // ---------------- execute / write-back register ----------------
  logic               wb_we_q;
  logic [FLD_W-1:0]   wb_dr_q;
  logic [DATA_W-1:0]  wb_data_q;
  logic [FLAG_W-1:0]  flags_q;

  // program counter
  assign ex_off_sx = {{EXT_W{ex_off[FLD_W-1]}}, ex_off};
  assign bz_taken  = ex_ctrl.is_bz && (ex_a == '0);
  assign redirect  = bz_taken || ex_ctrl.is_jmp;
  assign target    = ex_ctrl.is_jmp ? ex_a : (ex_pc + ex_off_sx);
  assign pc_next   = redirect ? target : (pc_q + DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      ir_q    <= '0;
      ir_pc_q <= '0;
    end else begin
      pc_q    <= pc_next;
      ir_q    <= imem_data;
      ir_pc_q <= pc_q;
    end
  end

  assign imem_addr = pc_q;

  // decode and operand fetch
  p4_decoder u_dec (
    .instr  (ir_q),
    .ctrl   (dec_ctrl),
    .fld_dr (dec_dr),
    .fld_sa (dec_sa),
    .fld_sb (dec_sb)
  );

  p4_regfile #(
    .DATA_W (DATA_W),
    .DEPTH  (REG_CNT)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wb_we_q),
    .waddr   (wb_dr_q),
    .wdata   (wb_data_q),
    .ra      (dec_sa),
    .rb      (dec_sb),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  assign const_zf = {{EXT_W{1'b0}}, dec_sb};
  assign opnd_b   = dec_ctrl.use_const ? const_zf : rd_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_ctrl <= ctrl_t'('0);
      ex_a    <= '0;
      ex_b    <= '0;
      ex_pc   <= '0;
      ex_dr   <= '0;
      ex_off  <= '0;
    end else begin
      ex_ctrl <= dec_ctrl;
      ex_a    <= rd_a;
      ex_b    <= opnd_b;
      ex_pc   <= ir_pc_q;
      ex_dr   <= dec_dr;
      ex_off  <= dec_sb;
    end
  end

  // execute: function unit and data memory side by side
  p4_func_unit #(
    .DATA_W (DATA_W)
  ) u_fu (
    .op    (ex_ctrl.fu_op),
    .a     (ex_a),
    .b     (ex_b),
    .res   (fu_res),
    .flags (fu_flags)
  );

  assign dmem_addr  = ex_a;
  assign dmem_wdata = ex_b;
  assign dmem_we    = ex_ctrl.mem_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_we_q   <= 1'b0;
      wb_dr_q   <= '0;
      wb_data_q <= '0;
      flags_q   <= '0;
    end else begin
      wb_we_q   <= ex_ctrl.rf_we;
      wb_dr_q   <= ex_dr;
      wb_data_q <= ex_ctrl.sel_mem ? dmem_rdata : fu_res;
      if (ex_ctrl.flag_we) flags_q <= fu_flags;
    end
  end

  // write-back
  assign rf_wr_en     = wb_we_q;
  assign rf_wr_addr   = wb_dr_q;
  assign rf_wr_data   = wb_data_q;
  assign status_flags = flags_q;

  // ---------------- assertions ----------------
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rf_wr_en && !dmem_we && imem_addr == '0));

  p_wb_from_ex_r6: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> $past(ex_ctrl.rf_we));

  p_seq_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> imem_addr == $past(imem_addr) + DATA_W'(1));

  p_bz_target_r8: assert property (@(posedge clk) disable iff (rst)
    bz_taken |=> imem_addr == $past(ex_pc) + $past(ex_off_sx));

  p_jmp_target_r10: assert property (@(posedge clk) disable iff (rst)
    ex_ctrl.is_jmp |=> imem_addr == $past(ex_a));

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl.flag_we |=> $stable(status_flags));

  p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !rf_wr_en);

endmodule

// File: tb/pipe4_core_bench.sv
module pipe4_core_bench;
  import pipe4_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int MEM_N      = 64;
  localparam int RUN_LEN    = 60;
  localparam int LAST_CYC   = 62;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [DW-1:0]      imem_addr;
  logic [INSTR_W-1:0] imem_data;
  logic [DW-1:0]      dmem_addr, dmem_wdata, dmem_rdata;
  logic               dmem_we;
  logic               rf_wr_en;
  logic [FLD_W-1:0]   rf_wr_addr;
  logic [DW-1:0]      rf_wr_data;
  logic [FLAG_W-1:0]  status_flags;

  logic [15:0] imem [MEM_N];
  logic [15:0] dmem [MEM_N];

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  pipe4_core #(.DATA_W(DW)) u_pipe4_core (
    .clk          (clk),
    .rst          (rst),
    .imem_addr    (imem_addr),
    .imem_data    (imem_data),
    .dmem_addr    (dmem_addr),
    .dmem_wdata   (dmem_wdata),
    .dmem_we      (dmem_we),
    .dmem_rdata   (dmem_rdata),
    .rf_wr_en     (rf_wr_en),
    .rf_wr_addr   (rf_wr_addr),
    .rf_wr_data   (rf_wr_data),
    .status_flags (status_flags)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // expected trace from the sequential model
  logic [2:0]  ew_a [MEM_N];
  logic [15:0] ew_d [MEM_N];
  logic [3:0]  ew_f [MEM_N];
  int          ew_c [MEM_N];
  string       ew_r [MEM_N];
  logic [15:0] es_a [MEM_N];
  logic [15:0] es_d [MEM_N];
  int          es_c [MEM_N];
  int nw, ns, wi, si;

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] enc(input logic [6:0] op, input int d, input int a, input int b);
    return {op, d[2:0], a[2:0], b[2:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < MEM_N; i++) imem[i] = enc(OPC_NOP, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1 fetch address in reset", imem_addr, 0);
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic goto_cyc(input int n);
    while (cyc < n) step();
  endtask

  task automatic add_wr(input int d, input logic [15:0] v, input logic [3:0] f, input int k, input string r);
    ew_a[nw] = d[2:0]; ew_d[nw] = v; ew_f[nw] = f; ew_c[nw] = k + 3; ew_r[nw] = r;
    nw++;
  endtask

  // sequential reference for straight-line code
  task automatic build_model();
    logic [15:0] r [8];
    logic [15:0] m [MEM_N];
    logic [3:0]  f;
    logic [15:0] ins, res, va, vb;
    logic [6:0]  op;
    logic        c;
    int d, a, b;
    for (int i = 0; i < MEM_N; i++) m[i] = dmem[i];
    for (int i = 0; i < 8; i++) r[i] = '0;
    f = '0; nw = 0; ns = 0;
    for (int k = 0; k < RUN_LEN; k++) begin
      ins = imem[k];
      op = ins[15:9]; d = int'(ins[8:6]); a = int'(ins[5:3]); b = int'(ins[2:0]);
      va = r[a]; vb = r[b];
      case (op)
        OPC_ADD: begin
          {c, res} = {1'b0, va} + {1'b0, vb};
          f = {(va[15] == vb[15]) && (res[15] != va[15]), c, res[15], res == 16'h0};
          r[d] = res; add_wr(d, res, f, k, "R3 add");
        end
        OPC_OR: begin
          res = va | vb; f = {1'b0, 1'b0, res[15], res == 16'h0};
          r[d] = res; add_wr(d, res, f, k, "R3 or");
        end
        OPC_SHR: begin
          res = vb >> 1; f = {1'b0, vb[0], 1'b0, res == 16'h0};
          r[d] = res; add_wr(d, res, f, k, "R3 shift");
        end
        OPC_LDI: begin
          res = {13'h0, ins[2:0]}; r[d] = res; add_wr(d, res, f, k, "R4 constant");
        end
        OPC_LD: begin
          res = m[va[5:0]]; r[d] = res; add_wr(d, res, f, k, "R5 load");
        end
        OPC_ST: begin
          m[va[5:0]] = vb; es_a[ns] = va; es_d[ns] = vb; es_c[ns] = k + 2; ns++;
        end
        default: ;
      endcase
    end
  endtask

  task automatic monitor();
    if (cyc < 3) begin
      check_eq("R1 no write after reset", {rf_wr_en, dmem_we}, 0);
    end
    if (rf_wr_en) begin
      if (wi < nw) begin
        check_eq({ew_r[wi], " R2 dest"}, rf_wr_addr, ew_a[wi]);
        check_eq({ew_r[wi], " R7 data"}, rf_wr_data, ew_d[wi]);
        check_eq("R11 flags", status_flags, ew_f[wi]);
        check_eq("R6 write cycle", cyc, ew_c[wi]);
        wi++;
      end else begin
        check_eq("R2 unexpected register write", 1, 0);
      end
    end
    if (dmem_we) begin
      if (si < ns) begin
        check_eq("R5 store address", dmem_addr, es_a[si]);
        check_eq("R5 store data", dmem_wdata, es_d[si]);
        check_eq("R6 store cycle", cyc, es_c[si]);
        si++;
      end else begin
        check_eq("R2 unexpected store", 1, 0);
      end
      dmem[dmem_addr[5:0]] = dmem_wdata;
    end
  endtask

  task automatic run_line();
    build_model();
    wi = 0; si = 0;
    do_reset();
    while (cyc <= LAST_CYC) begin
      monitor();
      step();
    end
    check_eq("R6 write count", wi, nw);
    check_eq("R5 store count", si, ns);
  endtask

  task automatic load_fixed();
    clear_prog();
    for (int i = 0; i < MEM_N; i++) dmem[i] = 16'($urandom);
    dmem[0] = 16'hFFFF; dmem[1] = 16'h0001; dmem[2] = 16'h7FFF; dmem[3] = 16'h8000;
    imem[0]  = enc(OPC_LDI, 0, 0, 0);
    imem[1]  = enc(OPC_LDI, 1, 0, 1);
    imem[2]  = enc(OPC_LDI, 5, 0, 2);
    imem[3]  = enc(OPC_LDI, 6, 0, 3);
    imem[4]  = enc(OPC_LD,  2, 0, 0);
    imem[5]  = enc(OPC_LD,  3, 1, 0);
    imem[6]  = enc(OPC_LD,  4, 5, 0);
    imem[7]  = enc(OPC_ADD, 7, 2, 3);   // FFFF+1: C and Z
    imem[9]  = enc(OPC_ADD, 7, 4, 3);   // 7FFF+1: V and N
    imem[11] = enc(OPC_SHR, 7, 0, 3);   // 1>>1: C and Z
    imem[12] = enc(OPC_OR,  7, 4, 2);   // FFFF: N
    imem[13] = enc(OPC_ST,  0, 0, 4);
    imem[14] = enc(OPC_LDI, 2, 0, 5);
    imem[16] = enc(OPC_LD,  7, 0, 0);
    imem[17] = enc(7'h7F, 7, 7, 7);     // undefined opcode
    imem[18] = enc(OPC_ST,  0, 6, 7);
  endtask

  task automatic gen_random();
    logic [6:0] ops [8];
    ops[0] = OPC_ADD; ops[1] = OPC_OR; ops[2] = OPC_SHR; ops[3] = OPC_LDI;
    ops[4] = OPC_LD;  ops[5] = OPC_ST; ops[6] = 7'h55;   ops[7] = OPC_ADD;
    clear_prog();
    for (int i = 0; i < MEM_N; i++) dmem[i] = 16'($urandom);
    dmem[0] = 16'hFFFF; dmem[1] = 16'h0001; dmem[2] = 16'h7FFF; dmem[3] = 16'h8000;
    for (int k = 0; k < 8; k++) imem[k] = enc(OPC_LDI, k, int'($urandom % 8), int'($urandom % 8));
    for (int j = 0; j < 24; j++) begin
      imem[9 + 2 * j]  = enc(ops[$urandom % 8], int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      imem[10 + 2 * j] = enc(OPC_NOP, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0420));

    // straight-line programs against the sequential model
    load_fixed();
    run_line();
    for (int t = 0; t < 4; t++) begin
      gen_random();
      run_line();
    end

    // seven independent constant loads: last result in cycle 9 (10 cycles)
    clear_prog();
    for (int k = 0; k < 7; k++) imem[k] = enc(OPC_LDI, k, 0, 7 - k);
    do_reset();
    goto_cyc(9);
    check_eq("R6 seventh write in cycle 9", {rf_wr_en, rf_wr_addr, rf_wr_data}, {1'b1, 3'd6, 16'd1});
    step();
    check_eq("R6 pipeline drained", rf_wr_en, 0);

    // taken branch backwards with two delay slots
    clear_prog();
    imem[0] = enc(OPC_LDI, 1, 0, 0);
    imem[1] = enc(OPC_LDI, 2, 0, 3);
    imem[3] = enc(OPC_BZ,  0, 1, 5);    // offset -3 -> address 0
    imem[4] = enc(OPC_LDI, 3, 0, 6);
    imem[5] = enc(OPC_LDI, 4, 0, 7);
    imem[6] = enc(OPC_LDI, 5, 0, 1);
    do_reset();
    goto_cyc(6);
    check_eq("R8 taken branch target", imem_addr, 0);
    goto_cyc(7);
    check_eq("R8 first delay slot", {rf_wr_en, rf_wr_addr, rf_wr_data}, {1'b1, 3'd3, 16'd6});
    goto_cyc(8);
    check_eq("R8 second delay slot", {rf_wr_en, rf_wr_addr, rf_wr_data}, {1'b1, 3'd4, 16'd7});
    goto_cyc(9);
    check_eq("R8 target instruction follows", {rf_wr_en, rf_wr_addr, rf_wr_data}, {1'b1, 3'd1, 16'd0});

    // branch not taken
    clear_prog();
    imem[0] = enc(OPC_LDI, 2, 0, 3);
    imem[2] = enc(OPC_BZ,  0, 2, 6);
    do_reset();
    goto_cyc(5);
    check_eq("R9 not taken stays sequential", imem_addr, 5);
    goto_cyc(6);
    check_eq("R9 next fetch", imem_addr, 6);

    // register jump, operand produced two slots earlier
    clear_prog();
    imem[0] = enc(OPC_LDI, 6, 0, 6);
    imem[2] = enc(OPC_JMP, 0, 6, 0);
    imem[3] = enc(OPC_LDI, 1, 0, 1);
    imem[4] = enc(OPC_LDI, 2, 0, 2);
    imem[5] = enc(OPC_LDI, 7, 0, 5);
    imem[6] = enc(OPC_LDI, 3, 0, 3);
    do_reset();
    goto_cyc(5);
    check_eq("R10 R7 jump target", imem_addr, 6);
    goto_cyc(6);
    check_eq("R10 first delay slot", {rf_wr_en, rf_wr_addr, rf_wr_data}, {1'b1, 3'd1, 16'd1});
    goto_cyc(7);
    check_eq("R10 second delay slot", {rf_wr_en, rf_wr_addr, rf_wr_data}, {1'b1, 3'd2, 16'd2});
    goto_cyc(8);
    check_eq("R10 skipped address not run", {rf_wr_en, rf_wr_addr, rf_wr_data}, {1'b1, 3'd3, 16'd3});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

endmodule